// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block evaluates arithmetic written for a stack machine. Each instruction does one of three things. It pushes an immediate word onto an internal register stack. It pops the top word out to the result port. Or it applies an arithmetic opcode that has no operand fields. Such an opcode takes the two topmost entries, combines them as (entry under the top) OP (top), and leaves the single result in their place. A nested expression is evaluated by issuing pushes and operations in postfix order, then one final pop.

Instructions arrive on a valid/ready handshake, and the unit takes one per cycle. Every accepted instruction produces a one-cycle response pulse. The response carries a data word and an error flag. Illegal requests leave the stack untouched and are reported through the error flag. Illegal requests are overflow, underflow, too few operands and unassigned opcodes. Division by zero is also flagged, but it still completes.

Top module: `stk_calc_unit`

## Requirements
- R1: While reset is high, in_ready is 0. After reset, in_ready is 1, out_valid is 0 and the stack is empty, so a first POP reports an error.
- R2: PUSH (in_op = 0) places in_data above all existing entries. Its response has out_err = 0 and out_data = 0. Successive POPs return the entries most-recent first.
- R3: POP (in_op = 1) on a non-empty stack removes the top entry and returns it on out_data with out_err = 0.
- R4: ADD (in_op = 2) and SUB (in_op = 3) compute second OP top modulo 2^16. The two sources are replaced by the result, which is also returned on out_data. PUSH A, PUSH B, SUB leaves A-B.
- R5: MUL (in_op = 4) keeps the low 16 bits of the product.
- R6: DIV (in_op = 5) gives the unsigned quotient second / top. With a zero divisor the result is 0xFFFF and out_err = 1, and both operands are still consumed.
- R7: PUSH to a stack holding 8 entries gives out_err = 1 and out_data = 0, and leaves the stack unchanged.
- R8: POP of an empty stack gives out_err = 1 and out_data = 0.
- R9: A binary opcode with fewer than two entries gives out_err = 1 and out_data = 0, and leaves the stack unchanged.
- R10: in_op values 6 and 7 give out_err = 1 and out_data = 0, and leave the stack unchanged.
- R11: out_valid is 1 exactly in the cycle after each accepted instruction. Back-to-back instructions are accepted on consecutive cycles.
- R12: A nested expression such as (A-B)/(C+D*E), issued in postfix order, yields its correct value on the final POP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit accepts an instruction this cycle |
| in_op | input | 3 | Opcode: 0 PUSH, 1 POP, 2 ADD, 3 SUB, 4 MUL, 5 DIV |
| in_data | input | 16 | Immediate word for PUSH |
| out_valid | output | 1 | Response pulse, one cycle after acceptance |
| out_data | output | 16 | Popped word or operation result |
| out_err | output | 1 | Request refused, or division by zero |

## Verification
Directed sequences push distinct values and pop them back, which exposes any ordering fault in the stack. SUB and DIV are given asymmetric operands, so a swapped operand order gives a visibly wrong result. The wrapping cases, ADD past 0xFFFF, SUB below zero and a MUL whose product is wider than 16 bits, separate modular truncation from saturation. Each refused request is followed by a POP, which shows that the stack kept its contents. A divide by zero is followed by draining the stack, which shows that both operands were consumed. A back-to-back burst and a full postfix expression cover consecutive acceptance and deep nesting.

// File: rtl/stk_calc_pkg.sv
package stk_calc_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_FOLD = 2'd3
    } stack_act_e;

    function automatic logic is_binop(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/stk_calc_alu.sv
module stk_calc_alu
    import stk_calc_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  op_e          op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res,
    output logic         div_zero
);

    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] prod;

    always_comb begin
        prod     = PW'(lhs) * PW'(rhs);
        div_zero = 1'b0;
        res      = '0;
        case (op)
            OP_ADD: res = lhs + rhs;
            OP_SUB: res = lhs - rhs;
            OP_MUL: res = prod[W-1:0];
            OP_DIV: begin
                if (rhs == '0) begin
                    res      = '1;
                    div_zero = 1'b1;
                end else begin
                    res = lhs / rhs;
                end
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_calc_stack.sv
module stk_calc_stack
    import stk_calc_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned DEPTH = stk_calc_pkg::DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  stack_act_e                 act,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               top_o,
    output logic [W-1:0]               next_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] fold_slot;

    assign fold_slot = count - CNT_W'(2);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if ((act == ST_PUSH && count == CNT_W'(i)) ||
                (act == ST_FOLD && count >= CNT_W'(2) && fold_slot == CNT_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (act)
                ST_PUSH: count <= count + CNT_W'(1);
                ST_POP,
                ST_FOLD: count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign top_o   = (count >= CNT_W'(1)) ? mem[IDX_W'(count - CNT_W'(1))] : '0;
    assign next_o  = (count >= CNT_W'(2)) ? mem[IDX_W'(count - CNT_W'(2))] : '0;
    assign count_o = count;

    // Occupancy never exceeds the capacity (R7)
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // A push makes the written word the new top (R2)
    assert_push_on_top_R2: assert property (@(posedge clk) disable iff (rst)
        (act == ST_PUSH) |=> (top_o == $past(wdata) && count == $past(count) + CNT_W'(1)));

    // A fold replaces two entries by the result (R4)
    assert_fold_result_R4: assert property (@(posedge clk) disable iff (rst)
        (act == ST_FOLD) |=> (top_o == $past(wdata) && count == $past(count) - CNT_W'(1)));

    // Holding leaves the stack untouched (R9)
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (act == ST_HOLD) |=> ($stable(count) && $stable(top_o)));

endmodule

// File: rtl/stk_calc_unit.sv
module stk_calc_unit
    import stk_calc_pkg::*;
#(
    parameter int unsigned DATA_W = stk_calc_pkg::DATA_W,
    parameter int unsigned DEPTH  = stk_calc_pkg::DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] data;
    } resp_t;

    op_e               op;
    logic              accept;
    stack_act_e        act;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] top_w;
    logic [DATA_W-1:0] next_w;
    logic [CNT_W-1:0]  depth;
    logic [DATA_W-1:0] alu_res;
    logic              alu_dz;
    resp_t             resp_d;
    resp_t             resp_q;
    logic              valid_q;

    assign op       = op_e'(in_op);
    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    stk_calc_stack #(.W(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wdata   (wdata),
        .top_o   (top_w),
        .next_o  (next_w),
        .count_o (depth)
    );

    stk_calc_alu #(.W(DATA_W)) u_alu (
        .op       (op),
        .lhs      (next_w),
        .rhs      (top_w),
        .res      (alu_res),
        .div_zero (alu_dz)
    );

    always_comb begin
        act    = ST_HOLD;
        wdata  = in_data;
        resp_d = '0;
        if (accept) begin
            if (op == OP_PUSH) begin
                if (depth == CNT_W'(DEPTH)) resp_d.err = 1'b1;
                else                        act = ST_PUSH;
            end else if (op == OP_POP) begin
                if (depth == '0) begin
                    resp_d.err = 1'b1;
                end else begin
                    act         = ST_POP;
                    resp_d.data = top_w;
                end
            end else if (is_binop(op)) begin
                if (depth < CNT_W'(2)) begin
                    resp_d.err = 1'b1;
                end else begin
                    act         = ST_FOLD;
                    wdata       = alu_res;
                    resp_d.data = alu_res;
                    resp_d.err  = alu_dz;
                end
            end else begin
                resp_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            resp_q  <= '0;
        end else begin
            valid_q <= accept;
            resp_q  <= accept ? resp_d : '0;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = resp_q.data;
    assign out_err   = resp_q.err;

    // Response one cycle after acceptance (R11)
    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // No response without acceptance (R11)
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    // Popping an empty stack is refused (R8)
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_POP && depth == '0) |=> (out_err && out_data == '0 && depth == '0));

    // Zero divisor gives all ones, flags and consumes (R6)
    assert_div_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_DIV && depth >= CNT_W'(2) && top_w == '0)
        |=> (out_err && out_data == '1 && depth == $past(depth) - CNT_W'(1)));

    // Full stack refuses a push (R7)
    assert_push_full_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_PUSH && depth == CNT_W'(DEPTH)) |=> (out_err && $stable(depth)));

endmodule

// File: tb/sim_stk_calc_unit.sv
`timescale 1ns/1ps
module sim_stk_calc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_op;
    logic [15:0] in_data;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_err;

    int vec_n = 0;
    int bad_n = 0;
    bit done  = 1'b0;

    localparam logic [2:0] PUSH = 3'd0, POP = 3'd1, ADD = 3'd2, SUB = 3'd3,
                           MUL  = 3'd4, DIV = 3'd5;

    always #2.5 clk = ~clk;

    stk_calc_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_err(out_err)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [17:0] act, input logic [17:0] exp);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s: actual {valid,err,data}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [15:0] d,
                         input logic ee, input logic [15:0] ed, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1 && out_err === ee && out_data === ed, tag,
              {out_valid, out_err, out_data}, {1'b1, ee, ed});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_data = '0;
        repeat (3) @(negedge clk);
        check(in_ready === 1'b0, "R1 ready low in reset", {17'd0, in_ready}, 18'd0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1 idle after reset",
              {16'd0, in_ready, out_valid}, 18'd2);
        do_op(POP, 16'h0, 1'b1, 16'h0, "R1 empty after reset");
    endtask

    task automatic t_lifo;
        do_op(PUSH, 16'h00A1, 1'b0, 16'h0, "R2 push a");
        do_op(PUSH, 16'h00B2, 1'b0, 16'h0, "R2 push b");
        do_op(PUSH, 16'h00C3, 1'b0, 16'h0, "R2 push c");
        do_op(POP, 16'h0, 1'b0, 16'h00C3, "R3 pop newest");
        do_op(POP, 16'h0, 1'b0, 16'h00B2, "R2 pop middle");
        do_op(POP, 16'h0, 1'b0, 16'h00A1, "R2 pop oldest");
    endtask

    task automatic t_addsub;
        do_op(PUSH, 16'd3, 1'b0, 16'h0, "R4 push");
        do_op(PUSH, 16'd5, 1'b0, 16'h0, "R4 push");
        do_op(SUB, 16'h0, 1'b0, 16'hFFFE, "R4 sub order and wrap");
        do_op(PUSH, 16'd4, 1'b0, 16'h0, "R4 push");
        do_op(ADD, 16'h0, 1'b0, 16'h0002, "R4 add wrap");
        do_op(POP, 16'h0, 1'b0, 16'h0002, "R4 result on top");
        do_op(POP, 16'h0, 1'b1, 16'h0, "R4 depth shrank");
        do_op(PUSH, 16'd50, 1'b0, 16'h0, "R4 push");
        do_op(PUSH, 16'd8, 1'b0, 16'h0, "R4 push");
        do_op(SUB, 16'h0, 1'b0, 16'd42, "R4 sub A-B");
        do_op(POP, 16'h0, 1'b0, 16'd42, "R4 pop A-B");
    endtask

    task automatic t_mul;
        do_op(PUSH, 16'h1234, 1'b0, 16'h0, "R5 push");
        do_op(PUSH, 16'h0100, 1'b0, 16'h0, "R5 push");
        do_op(MUL, 16'h0, 1'b0, 16'h3400, "R5 low product");
        do_op(POP, 16'h0, 1'b0, 16'h3400, "R5 pop");
    endtask

    task automatic t_div;
        do_op(PUSH, 16'd100, 1'b0, 16'h0, "R6 push");
        do_op(PUSH, 16'd7, 1'b0, 16'h0, "R6 push");
        do_op(DIV, 16'h0, 1'b0, 16'd14, "R6 quotient order");
        do_op(PUSH, 16'd0, 1'b0, 16'h0, "R6 push zero");
        do_op(DIV, 16'h0, 1'b1, 16'hFFFF, "R6 divide by zero");
        do_op(POP, 16'h0, 1'b0, 16'hFFFF, "R6 all ones on top");
        do_op(POP, 16'h0, 1'b1, 16'h0, "R6 both consumed");
    endtask

    task automatic t_full;
        for (int i = 1; i <= 8; i++)
            do_op(PUSH, 16'(i), 1'b0, 16'h0, "R7 fill");
        do_op(PUSH, 16'hDEAD, 1'b1, 16'h0, "R7 push full");
        do_op(POP, 16'h0, 1'b0, 16'd8, "R7 top unchanged");
        for (int i = 7; i >= 1; i--)
            do_op(POP, 16'h0, 1'b0, 16'(i), "R7 drain");
    endtask

    task automatic t_empty;
        do_op(POP, 16'h0, 1'b1, 16'h0, "R8 pop empty");
        do_op(POP, 16'h0, 1'b1, 16'h0, "R8 pop empty again");
    endtask

    task automatic t_short;
        do_op(ADD, 16'h0, 1'b1, 16'h0, "R9 add on empty");
        do_op(PUSH, 16'h0055, 1'b0, 16'h0, "R9 push");
        do_op(DIV, 16'h0, 1'b1, 16'h0, "R9 div one entry");
        do_op(MUL, 16'h0, 1'b1, 16'h0, "R9 mul one entry");
        do_op(POP, 16'h0, 1'b0, 16'h0055, "R9 stack kept");
    endtask

    task automatic t_reserved;
        do_op(PUSH, 16'h0011, 1'b0, 16'h0, "R10 push");
        do_op(PUSH, 16'h0022, 1'b0, 16'h0, "R10 push");
        do_op(3'd6, 16'h0, 1'b1, 16'h0, "R10 opcode 6");
        do_op(3'd7, 16'h0, 1'b1, 16'h0, "R10 opcode 7");
        do_op(POP, 16'h0, 1'b0, 16'h0022, "R10 top kept");
        do_op(POP, 16'h0, 1'b0, 16'h0011, "R10 second kept");
    endtask

    task automatic t_burst;
        @(negedge clk);
        in_valid = 1'b1; in_op = PUSH; in_data = 16'd11;
        @(negedge clk);
        check(out_valid === 1'b1 && out_err === 1'b0, "R11 burst push 1",
              {out_valid, out_err, out_data}, {2'b10, 16'h0});
        in_data = 16'd22;
        @(negedge clk);
        check(out_valid === 1'b1 && out_err === 1'b0, "R11 burst push 2",
              {out_valid, out_err, out_data}, {2'b10, 16'h0});
        in_op = POP;
        @(negedge clk);
        check(out_valid === 1'b1 && out_data === 16'd22, "R11 burst pop 1",
              {out_valid, out_err, out_data}, {2'b10, 16'd22});
        @(negedge clk);
        check(out_valid === 1'b1 && out_data === 16'd11, "R11 burst pop 2",
              {out_valid, out_err, out_data}, {2'b10, 16'd11});
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R11 no response when idle",
              {out_valid, out_err, out_data}, 18'd0);
    endtask

    task automatic t_nested;
        do_op(PUSH, 16'd100, 1'b0, 16'h0, "R12 A");
        do_op(PUSH, 16'd4, 1'b0, 16'h0, "R12 B");
        do_op(SUB, 16'h0, 1'b0, 16'd96, "R12 A-B");
        do_op(PUSH, 16'd2, 1'b0, 16'h0, "R12 C");
        do_op(PUSH, 16'd3, 1'b0, 16'h0, "R12 D");
        do_op(PUSH, 16'd10, 1'b0, 16'h0, "R12 E");
        do_op(MUL, 16'h0, 1'b0, 16'd30, "R12 D*E");
        do_op(ADD, 16'h0, 1'b0, 16'd32, "R12 C+D*E");
        do_op(DIV, 16'h0, 1'b0, 16'd3, "R12 divide");
        do_op(POP, 16'h0, 1'b0, 16'd3, "R12 final pop");
    endtask

    initial begin
        t_reset;
        t_lifo;
        t_addsub;
        t_mul;
        t_div;
        t_full;
        t_empty;
        t_short;
        t_reserved;
        t_burst;
        t_nested;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vec_n++;
            bad_n++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
            $finish;
        end
    end

endmodule